// File: doc/BRIEF.md
# Frame Strobe Reset Qualifier

This block watches a frame strobe on the data clock and decides whether a FIFO pointer reset should be requested. The strobe must stay high for a minimum number of data-clock beats. That minimum is the number of beats needed to carry one complete sample on the input bus, so it depends on whether the bus runs in word, byte or nibble mode. A strobe that is held long enough produces one request pulse of one cycle. A type flag travels with the pulse and tells the pointer logic whether to apply a relative reset or an absolute reset.

The reset type comes from the synchronization mode. Relative requests are also gated by a data-rate enable bit. A strobe that stays high past its qualifying point issues only one request. The strobe must drop low for at least one sampled cycle before it can arm again. The FIFO and the assembly of data words are outside this block.

Top module: `frame_reset_qualifier`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `rst_req` and `rst_abs` are 0.
- R2: The default input stage is one register. The request `rst_req` goes high for one cycle exactly N rising edges after the first edge that samples `frame_in` high, where N is the minimum width. It goes high only if `frame_in` was sampled high on N consecutive edges.
- R3: Byte mode is `bus_mode` = 01, with N = 2. A strobe sampled high on a single edge gives no request.
- R4: Nibble mode is `bus_mode` = 10, with N = 4. A strobe sampled high on 3 edges gives no request.
- R5: Word mode is `bus_mode` = 00, with N = 1. The value 11 behaves exactly like word mode.
- R6: With synchronization off (`sync_mode` = 00), a qualifying strobe requests a relative reset (`rst_abs` = 0).
- R7: In data-rate synchronization (`sync_mode` = 01), a qualifying strobe requests a relative reset.
- R8: In FIFO synchronization (`sync_mode` = 10), a qualifying strobe requests an absolute reset (`rst_abs` = 1). This happens whatever the value of `rate_mode_en`.
- R9: `sync_mode` = 11 behaves as synchronization off.
- R10: A relative request is issued only when `rate_mode_en` is 1. Otherwise the qualifying strobe produces no pulse.
- R11: Each strobe assertion gives at most one request, however long it stays high. After one sampled low cycle, the next assertion can qualify again.
- R12: `rst_req` never stays high two cycles in a row, and `rst_abs` is 0 whenever `rst_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_in | input | 1 | Frame strobe |
| bus_mode | input | 2 | 00 word, 01 byte, 10 nibble, 11 as word |
| sync_mode | input | 2 | 00 off, 01 data-rate, 10 FIFO, 11 as off |
| rate_mode_en | input | 1 | Permits relative requests |
| rst_req | output | 1 | One-cycle reset request |
| rst_abs | output | 1 | Request type: 1 absolute, 0 relative |

## Verification
The bench places strobes exactly one beat short of the minimum and exactly at the minimum in byte and nibble modes. An off-by-one width compare would either pass the short strobe or drop the exact one, and it would also shift the cycle in which the pulse appears. Long strobes and a strobe that drops for a single cycle test the re-arm logic. A design that forgot the armed state would repeat the pulse, and one that needed more than one low cycle would miss the second strobe. The reserved codes of both mode fields are driven, and so is the enable gating, including FIFO mode with the enable cleared. A wrong decode would flip the type flag or suppress an absolute reset.

// File: rtl/frq_pkg.sv
package frq_pkg;

  typedef enum logic [1:0] {
    BUS_WORD   = 2'b00,
    BUS_BYTE   = 2'b01,
    BUS_NIBBLE = 2'b10,
    BUS_RSVD   = 2'b11
  } frq_bus_e;

  typedef enum logic [1:0] {
    SYNC_OFF  = 2'b00,
    SYNC_RATE = 2'b01,
    SYNC_FIFO = 2'b10,
    SYNC_RSVD = 2'b11
  } frq_sync_e;

  // Beats the strobe must stay high for a given bus mode.
  function automatic int unsigned frq_min_beats(input logic [1:0] bm,
                                                input int unsigned word_b,
                                                input int unsigned byte_b,
                                                input int unsigned nib_b);
    case (frq_bus_e'(bm))
      BUS_BYTE:   return byte_b;
      BUS_NIBBLE: return nib_b;
      default:    return word_b;
    endcase
  endfunction

  // Only FIFO synchronization yields an absolute reset.
  function automatic logic frq_is_absolute(input logic [1:0] sm);
    return frq_sync_e'(sm) == SYNC_FIFO;
  endfunction

  function automatic int unsigned frq_max3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/frq_sampler.sv
module frq_sampler #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_in,
  output logic frame_q
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= frame_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], frame_in};
      end
    end
  endgenerate

  assign frame_q = stage_q[STAGES-1];
endmodule

// File: rtl/frq_width_counter.sv
module frq_width_counter
  import frq_pkg::*;
#(
  parameter int unsigned WORD_BEATS   = 1,
  parameter int unsigned BYTE_BEATS   = 2,
  parameter int unsigned NIBBLE_BEATS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_q,
  input  logic [1:0] bus_mode,
  output logic       qualify,
  output logic       armed
);
  localparam int unsigned MAX_BEATS = frq_max3(WORD_BEATS, BYTE_BEATS, NIBBLE_BEATS);
  localparam int unsigned CNT_W     = $clog2(MAX_BEATS + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BEATS);

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] run_next;
  logic [CNT_W-1:0] need_beats;
  logic             width_met;

  assign need_beats = CNT_W'(frq_min_beats(bus_mode, WORD_BEATS, BYTE_BEATS, NIBBLE_BEATS));
  assign run_next   = (run_cnt == CNT_SAT) ? run_cnt : run_cnt + 1'b1;
  assign width_met  = run_next >= need_beats;
  assign qualify    = frame_q && armed && width_met;

  always_ff @(posedge clk) begin
    if (!rst_n || !frame_q) run_cnt <= '0;
    else                    run_cnt <= run_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       armed <= 1'b1;
    else if (!frame_q) armed <= 1'b1;
    else if (qualify)  armed <= 1'b0;
  end

  // R11: one qualification per strobe; never on consecutive cycles
  a_r11_single_qualify: assert property (@(posedge clk) disable iff (!rst_n)
    qualify |=> !qualify);

  // R11: a low sample always leaves the counter ready for a new strobe
  a_r11_rearm_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_q |=> (armed && run_cnt == '0));
endmodule

// File: rtl/frq_mode_decoder.sv
module frq_mode_decoder
  import frq_pkg::*;
(
  input  logic [1:0] sync_mode,
  input  logic       rate_mode_en,
  output logic       want_abs,
  output logic       honour
);
  assign want_abs = frq_is_absolute(sync_mode);
  // Absolute resets always pass; relative ones need the data-rate enable.
  assign honour   = want_abs || rate_mode_en;
endmodule

// File: rtl/frame_reset_qualifier.sv
module frame_reset_qualifier
  import frq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 1,
  parameter int unsigned WORD_BEATS   = 1,
  parameter int unsigned BYTE_BEATS   = 2,
  parameter int unsigned NIBBLE_BEATS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_in,
  input  logic [1:0] bus_mode,
  input  logic [1:0] sync_mode,
  input  logic       rate_mode_en,
  output logic       rst_req,
  output logic       rst_abs
);
  logic frame_q;
  logic qualify;
  logic armed;
  logic want_abs;
  logic honour;
  logic fire;

  frq_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_in (frame_in),
    .frame_q  (frame_q)
  );

  frq_width_counter #(
    .WORD_BEATS   (WORD_BEATS),
    .BYTE_BEATS   (BYTE_BEATS),
    .NIBBLE_BEATS (NIBBLE_BEATS)
  ) u_width (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_q  (frame_q),
    .bus_mode (bus_mode),
    .qualify  (qualify),
    .armed    (armed)
  );

  frq_mode_decoder u_decode (
    .sync_mode    (sync_mode),
    .rate_mode_en (rate_mode_en),
    .want_abs     (want_abs),
    .honour       (honour)
  );

  assign fire = qualify && honour;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      rst_abs <= 1'b0;
    end else begin
      rst_req <= fire;
      rst_abs <= fire && want_abs;
    end
  end

  // R12: request lasts one cycle
  a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R12: type flag is quiet without a request
  a_r12_abs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req |-> !rst_abs);

  // R8: the type follows the synchronization mode of the qualifying cycle
  a_r8_type_from_mode: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_abs == ($past(sync_mode) == 2'b10)));

  // R10: a relative request implies the enable was set
  a_r10_rel_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !rst_abs) |-> $past(rate_mode_en));

  // R2: a request follows a high strobe sample while armed
  a_r2_req_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(frame_q) && $past(armed)));
endmodule

// File: tb/frame_reset_qualifier_tb.sv
module frame_reset_qualifier_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_in = 1'b0;
  logic [1:0] bus_mode = 2'b00;
  logic [1:0] sync_mode = 2'b00;
  logic       rate_mode_en = 1'b0;
  logic       rst_req;
  logic       rst_abs;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  frame_reset_qualifier u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_in     (frame_in),
    .bus_mode     (bus_mode),
    .sync_mode    (sync_mode),
    .rate_mode_en (rate_mode_en),
    .rst_req      (rst_req),
    .rst_abs      (rst_abs)
  );

  typedef struct packed {
    logic [1:0] bm;
    logic [1:0] sm;
    logic       en;
    logic [4:0] len;
    logic [1:0] pulses;
    logic       abs_exp;
    logic [2:0] width;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b00, 1'b1, 5'd1,  2'd1, 1'b0, 3'd1, 4'd2},  // R2 R6 word, off
    '{2'b01, 2'b00, 1'b1, 5'd1,  2'd0, 1'b0, 3'd2, 4'd3},  // R3 byte too short
    '{2'b01, 2'b01, 1'b1, 5'd2,  2'd1, 1'b0, 3'd2, 4'd3},  // R3 R7 byte exact
    '{2'b10, 2'b01, 1'b1, 5'd3,  2'd0, 1'b0, 3'd4, 4'd4},  // R4 nibble short
    '{2'b10, 2'b01, 1'b1, 5'd4,  2'd1, 1'b0, 3'd4, 4'd4},  // R4 nibble exact
    '{2'b10, 2'b10, 1'b0, 5'd9,  2'd1, 1'b1, 3'd4, 4'd8},  // R8 FIFO, enable low
    '{2'b11, 2'b10, 1'b1, 5'd1,  2'd1, 1'b1, 3'd1, 4'd5},  // R5 R8 reserved bus
    '{2'b00, 2'b00, 1'b0, 5'd3,  2'd0, 1'b0, 3'd1, 4'd10}, // R10 enable low
    '{2'b00, 2'b11, 1'b1, 5'd2,  2'd1, 1'b0, 3'd1, 4'd9},  // R9 reserved sync
    '{2'b01, 2'b01, 1'b0, 5'd5,  2'd0, 1'b0, 3'd2, 4'd10}, // R10 rate, no enable
    '{2'b00, 2'b01, 1'b1, 5'd10, 2'd1, 1'b0, 3'd1, 4'd11}  // R11 long strobe
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int pulses = 0;
    int at_i = 0;
    int abs_seen = 0;
    bit quiet_ok = 1'b1;
    string tag;
    tag = $sformatf("R%0d(bm=%0d sm=%0d en=%0d len=%0d)", v.req, v.bm, v.sm, v.en, v.len);
    @(negedge clk);
    bus_mode = v.bm;
    sync_mode = v.sm;
    rate_mode_en = v.en;
    frame_in = 1'b1;
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      if (i == int'(v.len)) frame_in = 1'b0;
      if (rst_req) begin
        pulses++;
        at_i = i;
        abs_seen = int'(rst_abs);
      end else if (rst_abs) begin
        quiet_ok = 1'b0;
      end
    end
    check(pulses == int'(v.pulses), {tag, " pulses"}, pulses, int'(v.pulses));
    if (v.pulses != 0) begin
      check(at_i == int'(v.width) + 1, {tag, " R2 timing"}, at_i, int'(v.width) + 1);
      check(abs_seen == int'(v.abs_exp), {tag, " type"}, abs_seen, int'(v.abs_exp));
    end
    check(quiet_ok, {tag, " R12 abs quiet"}, int'(!quiet_ok), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int pulses;
    // R1: reset holds outputs low even with the strobe high
    frame_in = 1'b1;
    rate_mode_en = 1'b1;
    repeat (4) @(negedge clk);
    check(rst_req == 1'b0 && rst_abs == 1'b0, "R1 during reset", int'({rst_req, rst_abs}), 0);
    frame_in = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(rst_req == 1'b0 && rst_abs == 1'b0, "R1 after release", int'({rst_req, rst_abs}), 0);
    repeat (3) @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R11: high 3, low 1, high 1 in word mode gives two requests
    @(negedge clk);
    bus_mode = 2'b00;
    sync_mode = 2'b01;
    rate_mode_en = 1'b1;
    pulses = 0;
    for (int i = 1; i <= 16; i++) begin
      frame_in = (i <= 3) || (i == 5);
      @(negedge clk);
      if (rst_req) pulses++;
    end
    frame_in = 1'b0;
    check(pulses == 2, "R11 rearm after one low cycle", pulses, 2);

    // R11: a strobe held high across many cycles yields a single request
    pulses = 0;
    frame_in = 1'b1;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (rst_req) pulses++;
    end
    frame_in = 1'b0;
    repeat (4) @(negedge clk);
    check(pulses == 1, "R11 held strobe single request", pulses, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule